// File: doc/BRIEF.md
# Dual Alarm Interrupt Router

This block takes two alarm event strobes, one from a time-of-day comparator and one from a watchdog counter, and steers them onto two interrupt pins. Each alarm sets a sticky flag, and software clears that flag with a one-cycle clear strobe. A select bit decides which alarm owns interrupt A. Interrupt B always carries the other alarm. The alarm generators themselves are outside this block.

Interrupt A is active low. It either follows its alarm's flag (level mode) or fires a pulse of fixed length for each event (pulse mode). Interrupt B follows its alarm's flag, and its active level can be set high or low. Both pins are open drain. Each pin is therefore modelled as a pull-down enable: 1 means the pin is driven low and 0 means it is released. All configuration inputs are captured on the clock, so a change takes effect after the next rising edge. The block runs from its own clock, and no supply-state input gates it.

All control and status pins are plain levels or strobes. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `alarm_irq_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both `irq_a_pull` and `irq_b_pull` are 0. The reset configuration is: select 0, pulse mode, B active low.
- R2: With the captured select at 0, interrupt A serves the time-of-day alarm and B serves the watchdog alarm. With the select at 1, the two are swapped.
- R3: An event sets its alarm flag at the next rising edge. A clear strobe resets the flag at the next rising edge. When an event and a clear arrive in the same cycle, the event wins. In level mode `irq_a_pull` equals the flag of A's alarm.
- R4: In pulse mode, an event of A's alarm makes `irq_a_pull` 1 for exactly PULSE_LEN cycles, starting at the next rising edge. The default PULSE_LEN is 16.
- R5: An event of A's alarm during a running pulse restarts the pulse at its full length.
- R6: Interrupt B is active exactly while the flag of B's alarm is set. A clear strobe for that alarm releases it after the next edge.
- R7: With `cfg_b_high` at 0, B is active low and `irq_b_pull` = active. With `cfg_b_high` at 1, B is active high and `irq_b_pull` = not active.
- R8: A change of the select bit acts at the next edge. In pulse mode, a change of the select bit without a same-cycle event for the newly selected alarm cancels any running pulse and never starts one.
- R9: In pulse mode, the flag clear strobes have no effect on `irq_a_pull`. Events of B's alarm have no effect on `irq_a_pull`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tod_evt | input | 1 | Time-of-day alarm event strobe |
| wdg_evt | input | 1 | Watchdog alarm event strobe |
| tod_clr | input | 1 | Clear strobe for the time-of-day flag |
| wdg_clr | input | 1 | Clear strobe for the watchdog flag |
| cfg_sel_wdg_a | input | 1 | 0: time-of-day on A; 1: watchdog on A |
| cfg_level_a | input | 1 | 0: A pulse mode; 1: A level mode |
| cfg_b_high | input | 1 | 0: B active low; 1: B active high |
| irq_a_pull | output | 1 | Pull-down enable of interrupt A |
| irq_b_pull | output | 1 | Pull-down enable of interrupt B |

## Verification
Every input, whether a strobe or a configuration bit, passes through exactly one register before it reaches a pin. Each result is therefore due one cycle after its stimulus: a flag change, the start of a pulse, a swap of routing or a change of polarity. A pulse then lasts PULSE_LEN cycles. The bench drives inputs on the falling edge. It advances its own requirement model at the rising edge and compares both pins at the following falling edge, so every check lands on the cycle in which the new value is due.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NUM_SRC = 2;

  typedef enum logic {
    SRC_TOD = 1'b0,
    SRC_WDG = 1'b1
  } alarm_src_e;

  typedef struct packed {
    logic sel_wdg_a;
    logic level_a;
    logic b_high;
  } irq_cfg_t;

  localparam irq_cfg_t CFG_RESET = '{sel_wdg_a: 1'b0, level_a: 1'b0, b_high: 1'b0};
endpackage

// File: rtl/alarm_flag_bank.sv
module alarm_flag_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  // one sticky flag per alarm; a set beats a clear in the same cycle
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o[g] <= 1'b0;
      else if (set_i[g])   flag_o[g] <= 1'b1;
      else if (clr_i[g])   flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import alarm_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_cfg_t cfg_i,
  output irq_cfg_t cfg_q,
  output logic     sel_change_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_i;
  end

  // select differs from its captured value: it flips at the coming edge
  assign sel_change_o = cfg_i.sel_wdg_a ^ cfg_q.sel_wdg_a;
endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int PULSE_LEN = 16,
  parameter int CNT_W     = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             cancel_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_o <= '0;
    else if (cancel_i)       cnt_o <= '0;
    else if (load_i)         cnt_o <= LOAD_VAL;
    else if (cnt_o != '0)    cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/alarm_irq_router.sv
module alarm_irq_router
  import alarm_irq_pkg::*;
#(
  parameter int PULSE_LEN = 16,
  localparam int CNT_W    = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tod_evt,
  input  logic wdg_evt,
  input  logic tod_clr,
  input  logic wdg_clr,
  input  logic cfg_sel_wdg_a,
  input  logic cfg_level_a,
  input  logic cfg_b_high,
  output logic irq_a_pull,
  output logic irq_b_pull
);
  irq_cfg_t           cfg_in;
  irq_cfg_t           cfg_q;
  logic               sel_change;
  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] flags;
  logic               tod_flag;
  logic               wdg_flag;
  logic               sel_q;
  logic               lvl_q;
  logic               pol_q;
  logic               a_evt_next;
  logic               pulse_load;
  logic               pulse_cancel;
  logic [CNT_W-1:0]   pulse_cnt;
  logic               pulse_on;
  logic               a_flag;
  logic               b_flag;
  logic               a_active;

  assign cfg_in = '{sel_wdg_a: cfg_sel_wdg_a, level_a: cfg_level_a, b_high: cfg_b_high};

  irq_cfg_reg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_i       (cfg_in),
    .cfg_q       (cfg_q),
    .sel_change_o(sel_change)
  );

  assign sel_q = cfg_q.sel_wdg_a;
  assign lvl_q = cfg_q.level_a;
  assign pol_q = cfg_q.b_high;

  always_comb begin
    evt_vec          = '0;
    clr_vec          = '0;
    evt_vec[SRC_TOD] = tod_evt;
    evt_vec[SRC_WDG] = wdg_evt;
    clr_vec[SRC_TOD] = tod_clr;
    clr_vec[SRC_WDG] = wdg_clr;
  end

  alarm_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_vec),
    .clr_i (clr_vec),
    .flag_o(flags)
  );

  assign tod_flag = flags[SRC_TOD];
  assign wdg_flag = flags[SRC_WDG];

  // pulse trigger follows the select value being captured this edge
  assign a_evt_next   = cfg_sel_wdg_a ? wdg_evt : tod_evt;
  assign pulse_load   = a_evt_next;
  assign pulse_cancel = cfg_level_a | (sel_change & ~a_evt_next);

  irq_pulse_timer #(.PULSE_LEN(PULSE_LEN), .CNT_W(CNT_W)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (pulse_load),
    .cancel_i(pulse_cancel),
    .cnt_o   (pulse_cnt)
  );

  assign pulse_on = (pulse_cnt != '0);

  // output routing works from captured configuration only
  assign a_flag   = sel_q ? wdg_flag : tod_flag;
  assign b_flag   = sel_q ? tod_flag : wdg_flag;
  assign a_active = lvl_q ? a_flag : pulse_on;

  // open drain: 1 pulls the pin low
  assign irq_a_pull = a_active;
  assign irq_b_pull = b_flag ^ pol_q;
endmodule

// File: rtl/alarm_irq_router_chk.sv
module alarm_irq_router_chk #(
  parameter int PULSE_LEN = 16,
  parameter int CNT_W     = $clog2(PULSE_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tod_evt,
  input logic             wdg_evt,
  input logic             tod_clr,
  input logic             cfg_sel_wdg_a,
  input logic             cfg_level_a,
  input logic             irq_a_pull,
  input logic             irq_b_pull,
  input logic             sel_q,
  input logic             lvl_q,
  input logic             pol_q,
  input logic             tod_flag,
  input logic             wdg_flag,
  input logic [CNT_W-1:0] pulse_cnt
);
  // R1: outputs are released right after reset is removed
  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_a_pull && !irq_b_pull));

  // R3: event sets the flag
  a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    tod_evt |=> tod_flag);

  // R3: clear without event drops the flag
  a_r3_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_clr && !tod_evt) |=> !tod_flag);

  // R2: level mode, select 0, A mirrors the time-of-day flag
  a_r2_route_tod: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q && !sel_q) |-> (irq_a_pull == tod_flag));

  // R2: level mode, select 1, A mirrors the watchdog flag
  a_r2_route_wdg: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q && sel_q) |-> (irq_a_pull == wdg_flag));

  // R4: pulse mode event asserts A next cycle
  a_r4_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_level_a && (cfg_sel_wdg_a ? wdg_evt : tod_evt)) |=> irq_a_pull);

  // R4: counter never exceeds the pulse length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CNT_W'(PULSE_LEN));

  // R8: an idle pulse-mode A stays idle without a selected event
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_q && !cfg_level_a && !irq_a_pull && !(cfg_sel_wdg_a ? wdg_evt : tod_evt))
    |=> !irq_a_pull);

  // R7: active-high B with no flag set is held low
  a_r7_b_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q && !tod_flag && !wdg_flag) |-> irq_b_pull);
endmodule

bind alarm_irq_router alarm_irq_router_chk #(.PULSE_LEN(PULSE_LEN), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tod_evt      (tod_evt),
  .wdg_evt      (wdg_evt),
  .tod_clr      (tod_clr),
  .cfg_sel_wdg_a(cfg_sel_wdg_a),
  .cfg_level_a  (cfg_level_a),
  .irq_a_pull   (irq_a_pull),
  .irq_b_pull   (irq_b_pull),
  .sel_q        (sel_q),
  .lvl_q        (lvl_q),
  .pol_q        (pol_q),
  .tod_flag     (tod_flag),
  .wdg_flag     (wdg_flag),
  .pulse_cnt    (pulse_cnt)
);

// File: tb/sim_alarm_irq_router.sv
module sim_alarm_irq_router;
  localparam int LEN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tod_evt = 0, wdg_evt = 0, tod_clr = 0, wdg_clr = 0;
  logic c_sel = 0, c_lvl = 0, c_pol = 0;
  logic irq_a_pull, irq_b_pull;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // requirement model state
  bit m_tod, m_wdg, m_sel, m_lvl, m_pol;
  int m_cnt;

  always #4 clk = ~clk;

  alarm_irq_router #(.PULSE_LEN(LEN)) u0 (
    .clk(clk), .rst_n(rst_n),
    .tod_evt(tod_evt), .wdg_evt(wdg_evt),
    .tod_clr(tod_clr), .wdg_clr(wdg_clr),
    .cfg_sel_wdg_a(c_sel), .cfg_level_a(c_lvl), .cfg_b_high(c_pol),
    .irq_a_pull(irq_a_pull), .irq_b_pull(irq_b_pull)
  );

  function automatic bit exp_a();
    if (m_lvl) return m_sel ? m_wdg : m_tod;
    return m_cnt != 0;
  endfunction

  function automatic bit exp_b();
    return (m_sel ? m_tod : m_wdg) ^ m_pol;
  endfunction

  task automatic model_reset();
    m_tod = 0; m_wdg = 0; m_sel = 0; m_lvl = 0; m_pol = 0; m_cnt = 0;
  endtask

  task automatic model_tick();
    bit a_evt;
    a_evt = c_sel ? wdg_evt : tod_evt;
    if (c_lvl)              m_cnt = 0;
    else if (a_evt)         m_cnt = LEN;
    else if (c_sel != m_sel) m_cnt = 0;
    else if (m_cnt > 0)     m_cnt = m_cnt - 1;
    if (tod_evt) m_tod = 1; else if (tod_clr) m_tod = 0;
    if (wdg_evt) m_wdg = 1; else if (wdg_clr) m_wdg = 0;
    m_sel = c_sel; m_lvl = c_lvl; m_pol = c_pol;
  endtask

  task automatic check(string tag, bit act, bit exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: edge, model update, check at falling edge, drop strobes
  task automatic cyc(string tag_a, string tag_b);
    string ta, tb;
    @(posedge clk);
    model_tick();
    @(negedge clk);
    ta = (tag_a != "") ? tag_a : (m_lvl ? "R3" : "R4");
    tb = (tag_b != "") ? tag_b : (m_pol ? "R7" : "R6");
    check(ta, irq_a_pull, exp_a(), "irq_a_pull");
    check(tb, irq_b_pull, exp_b(), "irq_b_pull");
    tod_evt = 0; wdg_evt = 0; tod_clr = 0; wdg_clr = 0;
  endtask

  task automatic run(int n, string ta, string tb);
    for (int i = 0; i < n; i++) cyc(ta, tb);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1384));
    model_reset();
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check("R1", irq_a_pull, 1'b0, "a in reset");
      check("R1", irq_b_pull, 1'b0, "b in reset");
    end
    rst_n = 1;
    run(1, "R1", "R1");

    // R2 / R3: level mode routing with select 0
    c_lvl = 1; run(1, "R3", "R6");
    tod_evt = 1; run(1, "R2", "R2");
    run(2, "R3", "R2");
    wdg_evt = 1; run(1, "R2", "R6");
    tod_clr = 1; run(1, "R3", "R6");
    wdg_clr = 1; run(1, "R3", "R6");
    // R3: set wins over clear
    tod_evt = 1; tod_clr = 1; run(1, "R3", "R6");
    tod_clr = 1; run(1, "R3", "R6");
    // R2: swapped routing
    c_sel = 1; run(1, "R2", "R2");
    tod_evt = 1; run(1, "R2", "R2");
    wdg_evt = 1; run(1, "R2", "R2");
    tod_clr = 1; wdg_clr = 1; run(1, "R2", "R6");
    // R7: polarity
    c_pol = 1; run(1, "R3", "R7");
    tod_evt = 1; run(1, "R2", "R7");
    tod_clr = 1; run(1, "R3", "R7");
    c_pol = 0; run(1, "R3", "R7");

    // R4: pulse length, select 1 (watchdog on A)
    c_lvl = 0; run(1, "R4", "R6");
    wdg_evt = 1; run(LEN + 3, "R4", "R6");
    // R9: B events and clears do not touch A's pulse
    wdg_evt = 1; run(2, "R9", "R6");
    wdg_clr = 1; tod_evt = 1; run(1, "R9", "R6");
    tod_clr = 1; run(LEN, "R9", "R6");
    // R5: retrigger restarts
    wdg_evt = 1; run(6, "R5", "R6");
    wdg_evt = 1; run(LEN + 2, "R5", "R6");
    // R8: swap cancels a running pulse without starting one
    wdg_evt = 1; run(4, "R8", "R6");
    c_sel = 0; run(LEN + 2, "R8", "R6");
    // R8: swap with an event of the newly selected source starts a pulse
    c_sel = 1; wdg_evt = 1; run(LEN + 2, "R8", "R6");
    wdg_clr = 1; tod_clr = 1; run(1, "R6", "R6");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      tod_evt = ($urandom_range(0, 19) == 0);
      wdg_evt = ($urandom_range(0, 19) == 0);
      tod_clr = ($urandom_range(0, 11) == 0);
      wdg_clr = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 79) == 0) c_sel = ~c_sel;
      if ($urandom_range(0, 149) == 0) c_lvl = ~c_lvl;
      if ($urandom_range(0, 99) == 0) c_pol = ~c_pol;
      cyc("", "");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule